// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block is the host side of a passive serial configuration link. It pulls a target programmable device out of user mode and feeds it a bitstream one bit at a time. The target is driven through three outputs: an active-low reconfiguration request, a serial clock and a single data line. The block watches three inputs from the target: an active-low status line, a done line and an optional init-complete line.

Bitstream bytes come in on a valid/ready stream that carries a last-byte marker. After a start pulse, the loader runs its sequence in order:

- pulses the request line;
- waits for the target to release status;
- lets a settle delay pass;
- shifts every byte out least significant bit first;
- waits for done;
- issues two trailing falling clock edges;
- optionally waits for init-complete.

Every delay and timeout is a parameter counted in system clock cycles. The sequence ends with a sticky success or error flag, so a supervisor can retry after an error.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset and while idle: cfg_req_n is 1, ser_clk, ser_data, in_ready and busy are 0, and cfg_ok and cfg_err are 0 until the first run ends.
- R2: A start pulse sampled while idle drives cfg_req_n low for exactly REQ_CYC cycles, clears cfg_ok and cfg_err, and raises busy. A start pulse while busy has no effect.
- R3: After cfg_req_n returns high, no serial clock is produced until tgt_status_n is sampled high. in_ready first rises SETTLE_CYC cycles after that sample.
- R4: A byte is taken on a cycle where in_valid and in_ready are both 1. in_ready is 1 only while shifting with no byte held. While no byte is held, ser_clk stays 0.
- R5: Each held byte goes out bit 0 first. Each bit spends HALF_CYC cycles with ser_clk low, then HALF_CYC cycles with ser_clk high. ser_data changes only while ser_clk is low.
- R6: If tgt_status_n is still low STATUS_TO cycles after cfg_req_n rises, the run ends in idle with cfg_err set.
- R7: After the last bit of a byte marked last, the loader waits for tgt_done. If tgt_done is not seen within DONE_TO cycles, the run ends with cfg_err.
- R8: tgt_status_n sampled low in any shifting cycle ends the run at the next edge, with cfg_err set.
- R9: Once tgt_done is sampled high, ser_clk goes high, low, high, low for HALF_CYC cycles each, which gives exactly two falling edges, and then rests low.
- R10: With USE_INIT set, cfg_ok is set when tgt_initd is sampled high within INIT_TO cycles after the trailing clocks. Otherwise cfg_err is set. With USE_INIT clear, cfg_ok is set straight after the trailing clocks.
- R11: cfg_ok and cfg_err are never 1 together, and each holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (taken only when idle) |
| in_valid | input | 1 | Bitstream byte available |
| in_ready | output | 1 | Loader takes the offered byte |
| in_data | input | BYTE_W | Bitstream byte, bit 0 sent first |
| in_last | input | 1 | Marks the final byte of the bitstream |
| cfg_req_n | output | 1 | Active-low reconfiguration request to the target |
| tgt_status_n | input | 1 | Active-low status from the target |
| tgt_done | input | 1 | Target reports the bitstream was received |
| tgt_initd | input | 1 | Target reports initialization finished |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| cfg_ok | output | 1 | Sticky: last run succeeded |
| cfg_err | output | 1 | Sticky: last run failed |

## Verification
Some properties are checked by assertions on every cycle:
- ser_data holds steady while ser_clk is high;
- a status drop during shifting leads straight to idle with the error flag;
- the trailing phase produces exactly two falling clock edges;
- a success with init monitoring always follows an init-complete sample;
- the two result flags never coincide.

Other behaviour can only be shown by the bench's scenarios, which compare every output on every cycle against a behavioural timeline. That covers:
- the exact request pulse width and settle delay;
- least-significant-bit-first ordering across several byte values;
- holding the clock low across stream gaps;
- an ignored start while busy;
- each of the three timeout paths.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SETTLE,
    ST_SHIFT,
    ST_DONECHK,
    ST_TRAIL,
    ST_INIT
  } cfg_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps_cfg_wcnt.sv
module ps_cfg_wcnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ps_cfg_serializer.sv
module ps_cfg_serializer #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              stream_end
);

  localparam int unsigned PER = 2 * HALF_CYC;
  localparam int unsigned PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int unsigned BW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PER - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(HALF_CYC);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic              held_q, held_d;
  logic              last_q, last_d;
  logic              wrap;

  assign wrap = held_q && (ph_q == PH_LAST);

  always_comb begin
    sreg_d = sreg_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    held_d = held_q;
    last_d = last_q;
    if (!en) begin
      held_d = 1'b0;
      ph_d   = '0;
      bit_d  = '0;
    end else if (!held_q) begin
      if (in_valid) begin
        sreg_d = in_data;
        last_d = in_last;
        held_d = 1'b1;
        ph_d   = '0;
        bit_d  = '0;
      end
    end else if (wrap) begin
      ph_d = '0;
      if (bit_q == BIT_LAST) held_d = 1'b0;
      else                   bit_d  = bit_q + BW'(1);
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      ph_q   <= '0;
      bit_q  <= '0;
      held_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      held_q <= held_d;
      last_q <= last_d;
    end
  end

  assign in_ready   = en && !held_q;
  assign sclk_o     = held_q && (ph_q >= PH_HIGH);
  assign sdata_o    = held_q && sreg_q[bit_q];
  assign stream_end = en && wrap && (bit_q == BIT_LAST) && last_q;

  // R4: never ask for a byte while a bit is being clocked high
  a_r4_no_ready_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !in_ready);

endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned HALF_CYC   = 2,
  parameter int unsigned REQ_CYC    = 4,
  parameter int unsigned SETTLE_CYC = 3,
  parameter int unsigned STATUS_TO  = 40,
  parameter int unsigned DONE_TO    = 20,
  parameter int unsigned INIT_TO    = 30,
  parameter bit          USE_INIT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              cfg_req_n,
  input  logic              tgt_status_n,
  input  logic              tgt_done,
  input  logic              tgt_initd,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              busy,
  output logic              cfg_ok,
  output logic              cfg_err
);

  localparam int unsigned MAXL = max2(max2(max2(REQ_CYC, SETTLE_CYC), max2(STATUS_TO, DONE_TO)),
                                      max2(INIT_TO, 4 * HALF_CYC));
  localparam int unsigned CW = $clog2(MAXL + 1);
  localparam logic [CW-1:0] L_REQ    = CW'(REQ_CYC - 1);
  localparam logic [CW-1:0] L_SETTLE = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] L_STAT   = CW'(STATUS_TO - 1);
  localparam logic [CW-1:0] L_DONE   = CW'(DONE_TO - 1);
  localparam logic [CW-1:0] L_INIT   = CW'(INIT_TO - 1);
  localparam logic [CW-1:0] L_TRAIL  = CW'(4 * HALF_CYC - 1);
  localparam logic [CW-1:0] T_H1     = CW'(HALF_CYC);
  localparam logic [CW-1:0] T_H2     = CW'(2 * HALF_CYC);
  localparam logic [CW-1:0] T_H3     = CW'(3 * HALF_CYC);

  cfg_state_e    st_q, st_d;
  logic          ok_q, ok_d, err_q, err_d;
  logic [CW-1:0] cnt;
  logic          ser_en, ser_sclk, ser_sdata, ser_end, trail_clk;

  ps_cfg_wcnt #(.CW(CW)) u_wcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_d != st_q),
    .cnt_o (cnt)
  );

  assign ser_en = (st_q == ST_SHIFT);

  ps_cfg_serializer #(.BYTE_W(BYTE_W), .HALF_CYC(HALF_CYC)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ser_en),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .sclk_o     (ser_sclk),
    .sdata_o    (ser_sdata),
    .stream_end (ser_end)
  );

  // next-state and result flags
  always_comb begin
    st_d  = st_q;
    ok_d  = ok_q;
    err_d = err_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_REQ;
        ok_d  = 1'b0;
        err_d = 1'b0;
      end
      ST_REQ:    if (cnt == L_REQ) st_d = ST_WAIT;
      ST_WAIT: begin
        if (tgt_status_n)        st_d = ST_SETTLE;
        else if (cnt == L_STAT) begin st_d = ST_IDLE; err_d = 1'b1; end
      end
      ST_SETTLE: if (cnt == L_SETTLE) st_d = ST_SHIFT;
      ST_SHIFT: begin
        if (!tgt_status_n) begin st_d = ST_IDLE; err_d = 1'b1; end
        else if (ser_end)  st_d = ST_DONECHK;
      end
      ST_DONECHK: begin
        if (tgt_done)           st_d = ST_TRAIL;
        else if (cnt == L_DONE) begin st_d = ST_IDLE; err_d = 1'b1; end
      end
      ST_TRAIL: if (cnt == L_TRAIL) begin
        if (USE_INIT) st_d = ST_INIT;
        else begin st_d = ST_IDLE; ok_d = 1'b1; end
      end
      ST_INIT: begin
        if (tgt_initd)          begin st_d = ST_IDLE; ok_d = 1'b1; end
        else if (cnt == L_INIT) begin st_d = ST_IDLE; err_d = 1'b1; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ok_q  <= ok_d;
      err_q <= err_d;
    end
  end

  assign trail_clk = (cnt < T_H1) || ((cnt >= T_H2) && (cnt < T_H3));
  assign ser_clk   = (ser_en && ser_sclk) || ((st_q == ST_TRAIL) && trail_clk);
  assign ser_data  = ser_en && ser_sdata;
  assign cfg_req_n = (st_q != ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign cfg_ok    = ok_q;
  assign cfg_err   = err_q;

  // assertion support: falling edges seen during the trailing phase
  logic       clk_prev_q;
  logic [1:0] falls_q;
  logic       fall_now;
  assign fall_now = (st_q == ST_TRAIL) && clk_prev_q && !ser_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      falls_q    <= '0;
    end else begin
      clk_prev_q <= ser_clk;
      if (st_q != ST_TRAIL) falls_q <= '0;
      else if (fall_now)    falls_q <= falls_q + 2'd1;
    end
  end

  // R5: data is steady across the high phase
  a_r5_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R8: status loss while shifting aborts with an error
  a_r8_status_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && !tgt_status_n) |=> (st_q == ST_IDLE && cfg_err));

  // R9: exactly two falling edges by the end of the trailing phase
  a_r9_two_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIL && cnt == L_TRAIL) |-> (({1'b0, falls_q} + {2'b00, fall_now}) == 3'd2));

  // R11: result flags are exclusive
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));

  generate
    if (USE_INIT) begin : g_init_chk
      // R10: success only follows an init-complete sample
      a_r10_ok_after_initd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ok) |-> $past(tgt_initd));
    end
  endgenerate

endmodule

// File: tb/ps_cfg_host_tb_top.sv
`timescale 1ns/1ps
module ps_cfg_host_tb_top;

  localparam int HC = 2, CL = 4, SK = 3, STO = 40, DW = 20, ITO = 30;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic cfg_req_n, st_n, tdone, tinit, ser_clk, ser_data, busy, cfg_ok, cfg_err;

  logic e_cfg, e_sclk, e_sdata, e_rdy, e_busy, e_ok, e_err;
  int checks = 0, fails = 0;

  ps_cfg_host #(.BYTE_W(8), .HALF_CYC(HC), .REQ_CYC(CL), .SETTLE_CYC(SK),
                .STATUS_TO(STO), .DONE_TO(DW), .INIT_TO(ITO), .USE_INIT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .cfg_req_n(cfg_req_n), .tgt_status_n(st_n),
    .tgt_done(tdone), .tgt_initd(tinit), .ser_clk(ser_clk), .ser_data(ser_data),
    .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err));

  task automatic cmp(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural timeline model ----------------
  task automatic model_end(bit good);
    e_busy = 0; e_cfg = 1; e_sclk = 0; e_sdata = 0; e_rdy = 0;
    e_ok = good; e_err = !good;
  endtask

  task automatic model_run();
    logic [7:0] b;
    logic lst;
    #1 e_busy = 1; e_ok = 0; e_err = 0; e_cfg = 0; e_sclk = 0; e_sdata = 0; e_rdy = 0;
    repeat (CL) @(posedge clk);
    #1 e_cfg = 1;
    for (int k = 1; ; k++) begin
      @(posedge clk);
      if (st_n) break;
      if (k == STO) begin #1 model_end(0); return; end
    end
    repeat (SK) @(posedge clk);
    forever begin
      #1 e_rdy = 1; e_sclk = 0; e_sdata = 0;
      do begin
        @(posedge clk);
        if (!st_n) begin #1 model_end(0); return; end
      end while (!in_valid);
      b = in_data; lst = in_last;
      for (int bi = 0; bi < 8; bi++) begin
        for (int p = 0; p < 2*HC; p++) begin
          #1 e_rdy = 0; e_sclk = (p >= HC); e_sdata = b[bi];
          @(posedge clk);
          if (!st_n) begin #1 model_end(0); return; end
        end
      end
      if (lst) break;
    end
    #1 e_sclk = 0; e_sdata = 0; e_rdy = 0;
    for (int k = 1; ; k++) begin
      @(posedge clk);
      if (tdone) break;
      if (k == DW) begin #1 model_end(0); return; end
    end
    for (int p = 0; p < 4*HC; p++) begin
      #1 e_sclk = (p < HC) || (p >= 2*HC && p < 3*HC);
      @(posedge clk);
    end
    #1 e_sclk = 0;
    for (int k = 1; ; k++) begin
      @(posedge clk);
      if (tinit) break;
      if (k == ITO) begin #1 model_end(0); return; end
    end
    #1 model_end(1);
  endtask

  initial begin
    e_cfg = 1; e_sclk = 0; e_sdata = 0; e_rdy = 0; e_busy = 0; e_ok = 0; e_err = 0;
    forever begin
      @(posedge clk);
      if (rst_n === 1'b1 && start === 1'b1) model_run();
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      cmp("R2 cfg_req_n", cfg_req_n, e_cfg);
      cmp("R5/R9 ser_clk", ser_clk, e_sclk);
      cmp("R5 ser_data", ser_data, e_sdata);
      cmp("R3/R4 in_ready", in_ready, e_rdy);
      cmp("R1/R2 busy", busy, e_busy);
      cmp("R10/R11 cfg_ok", cfg_ok, e_ok);
      cmp("R6/R7/R8 cfg_err", cfg_err, e_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic enter_cfg();
    pulse_start();
    st_n = 0; tdone = 0; tinit = 0;
    repeat (8) @(negedge clk);
    st_n = 1;
  endtask

  task automatic send_byte(logic [7:0] b, logic lst);
    @(negedge clk);
    in_valid = 1; in_data = b; in_last = lst;
    while (!in_ready) @(negedge clk);
    @(negedge clk) in_valid = 0; in_last = 0;
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; in_valid = 0; in_data = 0; in_last = 0;
    st_n = 1; tdone = 1; tinit = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 reset cfg_req_n", cfg_req_n, 1'b1);
    cmp("R1 reset ser_clk", ser_clk, 1'b0);
    cmp("R1 reset in_ready", in_ready, 1'b0);
    cmp("R1 reset busy", busy, 1'b0);
    cmp("R1 reset flags", cfg_ok | cfg_err, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // S1: full success, three bytes with gaps, ignored start mid-stream (R2)
    enter_cfg();
    send_byte(8'hA5, 0);
    pulse_start();
    repeat (3) @(negedge clk);
    send_byte(8'h3C, 0);
    send_byte(8'h81, 1);
    repeat (40) @(negedge clk);
    tdone = 1;
    repeat (4*HC + 6) @(negedge clk);
    tinit = 1;
    repeat (20) @(negedge clk);
    cmp("R10 success flag", cfg_ok, 1'b1);
    cmp("R11 no error on success", cfg_err, 1'b0);

    // S2: status never released (R6)
    pulse_start();
    st_n = 0; tdone = 0; tinit = 0;
    repeat (STO + CL + 10) @(negedge clk);
    cmp("R6 status timeout error", cfg_err, 1'b1);
    cmp("R11 ok cleared by new start", cfg_ok, 1'b0);
    cmp("R6 back to idle", busy, 1'b0);

    // S3: status drops mid-shift (R8)
    enter_cfg();
    send_byte(8'h5A, 0);
    repeat (10) @(negedge clk);
    st_n = 0;
    repeat (5) @(negedge clk);
    cmp("R8 abort error", cfg_err, 1'b1);
    cmp("R8 idle after abort", busy, 1'b0);
    st_n = 1;
    repeat (3) @(negedge clk);

    // S4: done never rises (R7); byte offered early during settle (R3)
    enter_cfg();
    send_byte(8'hC3, 1);
    repeat (32 + DW + 10) @(negedge clk);
    cmp("R7 done timeout error", cfg_err, 1'b1);

    // S5: init-complete never rises (R10)
    enter_cfg();
    send_byte(8'h0F, 1);
    repeat (40) @(negedge clk);
    tdone = 1;
    repeat (4*HC + ITO + 10) @(negedge clk);
    cmp("R10 init timeout error", cfg_err, 1'b1);
    cmp("R11 ok stays low", cfg_ok, 1'b0);
    cmp("R9 clock at rest", ser_clk, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule